// File: doc/BRIEF.md
# Multicast Frame Admission Controller

This block sits beside a switch's shared buffer pool and decides, for every multicast frame that arrives, whether it may take a buffer or must be discarded. It keeps a running count of the multicast frames currently held. It compares that count against three limits taken from its configuration pins. The first is a hard ceiling: the per-device cap minus the buffers reserved for remote multicast traffic. The second is a watermark set at a quarter step of the cap. It applies only to regular multicast frames, and only while IP-multicast priority is switched on. The third is a limit on how many frames may be admitted in a row before a release is seen.

An arrival strobe carries a flag that tells IP multicast apart from regular multicast. Exactly one cycle later the block answers with either an admit pulse or a drop pulse. A release strobe returns a buffer. The arrival and release strobes are plain single-cycle qualifiers, not valid/ready streams. The block can answer one arrival in every cycle, so it never applies back-pressure and has no ready output. Upstream logic must not hold a strobe high to repeat a request, because each high cycle counts as a separate frame.

Top module: `mc_admit_ctrl`

## Requirements
- R1: After reset, `occupancy` is 0 and neither `admit` nor `drop` is asserted.
- R2: Each cycle with `arr_valid` high is followed, one cycle later, by exactly one single-cycle pulse on `admit` or on `drop`. A cycle without an arrival is followed by neither pulse.
- R3: `occupancy` rises by one with each admitted frame and falls by one with each `rel_valid` cycle, in the same edge that registers the decision. An admit and a release in the same cycle leave it unchanged. A release while it is 0 is ignored.
- R4: Any frame, IP or regular, is dropped when `occupancy` is at or above `cfg_cap - cfg_rsv`. When `cfg_rsv >= cfg_cap` this ceiling is 0 and every frame is dropped.
- R5: The watermark level comes from `cfg_wm_sel` as follows: 2'b00 gives cap>>2, 2'b01 gives cap>>1, 2'b10 gives (cap>>1)+(cap>>2), and 2'b11 gives cap. Integer truncation applies, so cap 7 at 2'b10 gives 4.
- R6: A regular frame (`arr_ip`=0) is dropped when `occupancy` is at or above the watermark level and `cfg_ip_prio` is 1. When `cfg_ip_prio` is 0, or the frame is IP (`arr_ip`=1), the watermark has no effect.
- R7: When `cfg_fwd_limit` is nonzero, once that many frames have been admitted since the last release (or since reset), further arrivals are dropped until a release. A release restarts the run count, and the value 0 disables this limit.
- R8: A dropped frame does not change `occupancy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | 1 | One multicast frame arrives this cycle |
| arr_ip | input | 1 | Frame class: 1 = IP multicast, 0 = regular multicast |
| rel_valid | input | 1 | One multicast buffer is released this cycle |
| cfg_fwd_limit | input | FWD_W (5) | Admissions allowed between releases; 0 = unlimited |
| cfg_rsv | input | RSV_W (6) | Buffers held back for remote multicast reception |
| cfg_cap | input | CAP_W (9) | Per-device multicast frame cap |
| cfg_wm_sel | input | 2 | Watermark step: 00 25%, 01 50%, 10 75%, 11 100% |
| cfg_ip_prio | input | 1 | 1 = apply the watermark to regular multicast |
| admit | output | 1 | Pulse: the previous cycle's arrival was accepted |
| drop | output | 1 | Pulse: the previous cycle's arrival was refused |
| occupancy | output | CAP_W (9) | Multicast frames currently held |

## Verification
The admit or drop pulse for an arrival, and the occupancy change caused by that arrival or by a release in the same cycle, all become visible after the first rising edge that follows the strobe. Configuration is combinational into the decision, so a change takes effect for the arrival in the same cycle. The bench changes every input at a falling edge and reads `admit`, `drop` and `occupancy` at the next falling edge. This places each comparison in the one cycle where the result is due and catches pulses that come early, late or are stretched. Corner cases are run as directed sequences: truncating watermark arithmetic, a reservation larger than the cap, a release at zero, and the run limit.

// File: rtl/mc_adm_pkg.sv
package mc_adm_pkg;

  typedef enum logic [1:0] {
    WM_QUARTER = 2'b00,
    WM_HALF    = 2'b01,
    WM_THREE_Q = 2'b10,
    WM_FULL    = 2'b11
  } wm_sel_e;

endpackage

// File: rtl/mc_watermark.sv
module mc_watermark
  import mc_adm_pkg::*;
#(
  parameter int CAP_W = 9
) (
  input  logic [CAP_W-1:0] cap,
  input  logic [1:0]       sel,
  output logic [CAP_W-1:0] level
);

  logic [CAP_W-1:0] quarter;
  logic [CAP_W-1:0] half;

  assign quarter = cap >> 2;
  assign half    = cap >> 1;

  always_comb begin
    unique case (wm_sel_e'(sel))
      WM_QUARTER: level = quarter;
      WM_HALF:    level = half;
      WM_THREE_Q: level = half + quarter;
      default:    level = cap;
    endcase
  end

endmodule

// File: rtl/mc_occupancy.sv
module mc_occupancy #(
  parameter int CAP_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CAP_W-1:0] occ
);

  localparam logic [CAP_W-1:0] OCC_MAX = {CAP_W{1'b1}};

  logic [CAP_W-1:0] occ_q;
  logic [CAP_W-1:0] occ_d;

  always_comb begin
    occ_d = occ_q;
    unique case ({inc, dec})
      2'b10:   if (occ_q != OCC_MAX) occ_d = occ_q + 1'b1;
      2'b01:   if (occ_q != '0)      occ_d = occ_q - 1'b1;
      default: occ_d = occ_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_d;
  end

  assign occ = occ_q;

  AST_OCC_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> occ_q <= $past(occ_q)); // R3

  AST_OCC_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !dec |=> occ_q >= $past(occ_q)); // R3

endmodule

// File: rtl/mc_burst.sv
module mc_burst #(
  parameter int FWD_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  input  logic [FWD_W-1:0] limit,
  output logic             full
);

  localparam logic [FWD_W-1:0] RUN_MAX = {FWD_W{1'b1}};

  logic [FWD_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      run_q <= '0;
    else if (clr)                    run_q <= '0;
    else if (inc && run_q != RUN_MAX) run_q <= run_q + 1'b1;
  end

  assign full = (limit != '0) && (run_q >= limit);

  AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> run_q == '0); // R7

endmodule

// File: rtl/mc_admit_ctrl.sv
module mc_admit_ctrl #(
  parameter int FWD_W = 5,
  parameter int RSV_W = 6,
  parameter int CAP_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arr_valid,
  input  logic             arr_ip,
  input  logic             rel_valid,
  input  logic [FWD_W-1:0] cfg_fwd_limit,
  input  logic [RSV_W-1:0] cfg_rsv,
  input  logic [CAP_W-1:0] cfg_cap,
  input  logic [1:0]       cfg_wm_sel,
  input  logic             cfg_ip_prio,
  output logic             admit,
  output logic             drop,
  output logic [CAP_W-1:0] occupancy
);

  localparam int RSV_EXT = CAP_W - RSV_W;

  logic [CAP_W-1:0] rsv_ext;
  logic [CAP_W-1:0] hard_lim;
  logic [CAP_W-1:0] wm_level;
  logic             run_full;
  logic             hit_hard;
  logic             hit_wm;
  logic             refuse;
  logic             take;
  logic             admit_q;
  logic             drop_q;

  assign rsv_ext  = {{RSV_EXT{1'b0}}, cfg_rsv};
  assign hard_lim = (cfg_cap > rsv_ext) ? (cfg_cap - rsv_ext) : '0;

  mc_watermark #(.CAP_W(CAP_W)) u_wm (
    .cap   (cfg_cap),
    .sel   (cfg_wm_sel),
    .level (wm_level)
  );

  mc_burst #(.FWD_W(FWD_W)) u_run (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (take),
    .clr   (rel_valid),
    .limit (cfg_fwd_limit),
    .full  (run_full)
  );

  mc_occupancy #(.CAP_W(CAP_W)) u_occ (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (take),
    .dec   (rel_valid),
    .occ   (occupancy)
  );

  assign hit_hard = occupancy >= hard_lim;
  assign hit_wm   = cfg_ip_prio && !arr_ip && (occupancy >= wm_level);
  assign refuse   = hit_hard || hit_wm || run_full;
  assign take     = arr_valid && !refuse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      admit_q <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      admit_q <= take;
      drop_q  <= arr_valid && refuse;
    end
  end

  assign admit = admit_q;
  assign drop  = drop_q;

  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid |=> (admit ^ drop)); // R2

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_valid |=> !admit && !drop); // R2

  AST_DROP_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid && refuse |=> occupancy <= $past(occupancy)); // R8

  AST_UNDER_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> occupancy < hard_lim); // R4

endmodule

// File: tb/tb_mc_admit_ctrl.sv
module tb_mc_admit_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       arr_valid, arr_ip, rel_valid;
  logic [4:0] cfg_fwd_limit;
  logic [5:0] cfg_rsv;
  logic [8:0] cfg_cap;
  logic [1:0] cfg_wm_sel;
  logic       cfg_ip_prio;
  logic       admit, drop;
  logic [8:0] occupancy;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  mc_admit_ctrl dut (
    .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_ip(arr_ip),
    .rel_valid(rel_valid), .cfg_fwd_limit(cfg_fwd_limit), .cfg_rsv(cfg_rsv),
    .cfg_cap(cfg_cap), .cfg_wm_sel(cfg_wm_sel), .cfg_ip_prio(cfg_ip_prio),
    .admit(admit), .drop(drop), .occupancy(occupancy)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [8:0] cap;
    logic [5:0] rsv;
    logic [1:0] wm;
    logic       prio;
    logic [4:0] fwd;
    logic       arr;
    logic       ip;
    logic       rel;
    logic       e_adm;
    logic       e_drp;
    logic [8:0] e_occ;
  } vec_t;

  // Ceiling 8-2=6; 50% watermark of 8 = 4.
  localparam vec_t VEC [17] = '{
    '{4'd3, 9'd8, 6'd2, 2'd1, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 9'd1},
    '{4'd3, 9'd8, 6'd2, 2'd1, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 9'd2},
    '{4'd3, 9'd8, 6'd2, 2'd1, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 9'd3},
    '{4'd3, 9'd8, 6'd2, 2'd1, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 9'd4},
    '{4'd6, 9'd8, 6'd2, 2'd1, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 9'd4},
    '{4'd6, 9'd8, 6'd2, 2'd1, 1'b1, 5'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 9'd5},
    '{4'd6, 9'd8, 6'd2, 2'd1, 1'b1, 5'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 9'd6},
    '{4'd4, 9'd8, 6'd2, 2'd1, 1'b1, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 9'd6},
    '{4'd8, 9'd8, 6'd2, 2'd1, 1'b1, 5'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 9'd5},
    '{4'd3, 9'd8, 6'd2, 2'd1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 9'd4},
    '{4'd6, 9'd8, 6'd2, 2'd1, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 9'd5},
    '{4'd3, 9'd8, 6'd2, 2'd1, 1'b0, 5'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 9'd5},
    '{4'd2, 9'd8, 6'd2, 2'd1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'd5},
    '{4'd4, 9'd8, 6'd0, 2'd0, 1'b1, 5'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 9'd6},
    '{4'd5, 9'd8, 6'd0, 2'd0, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 9'd6},
    '{4'd5, 9'd8, 6'd0, 2'd3, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 9'd7},
    '{4'd5, 9'd8, 6'd0, 2'd2, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 9'd7}
  };

  function automatic string rname(input logic [3:0] r);
    case (r)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic ea, input logic ed,
                       input logic [8:0] eo);
    n_cmp++;
    if (admit !== ea || drop !== ed || occupancy !== eo) begin
      n_bad++;
      $display("FAIL %s: admit/drop/occ actual %b/%b/%0d expected %b/%b/%0d",
               req, admit, drop, occupancy, ea, ed, eo);
    end
  endtask

  task automatic set_cfg(input logic [8:0] cap, input logic [5:0] rsv,
                         input logic [1:0] wm, input logic prio,
                         input logic [4:0] fwd);
    cfg_cap = cap; cfg_rsv = rsv; cfg_wm_sel = wm;
    cfg_ip_prio = prio; cfg_fwd_limit = fwd;
  endtask

  // Drive at a falling edge, let one rising edge pass, sample at next falling edge.
  task automatic step(input logic a, input logic ip, input logic r);
    arr_valid = a; arr_ip = ip; rel_valid = r;
    @(posedge clk);
    @(negedge clk);
    arr_valid = 1'b0; arr_ip = 1'b0; rel_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    arr_valid = 1'b0; arr_ip = 1'b0; rel_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    set_cfg(9'd8, 6'd2, 2'd1, 1'b1, 5'd0);
    do_reset();
    check("R1", 1'b0, 1'b0, 9'd0);

    for (int i = 0; i < 17; i++) begin
      set_cfg(VEC[i].cap, VEC[i].rsv, VEC[i].wm, VEC[i].prio, VEC[i].fwd);
      step(VEC[i].arr, VEC[i].ip, VEC[i].rel);
      check(rname(VEC[i].req), VEC[i].e_adm, VEC[i].e_drp, VEC[i].e_occ);
    end
    step(1'b0, 1'b0, 1'b0);
    check("R2", 1'b0, 1'b0, 9'd7);  // drop pulse lasted one cycle only

    // R3: release while empty is ignored
    do_reset();
    check("R1", 1'b0, 1'b0, 9'd0);
    step(1'b0, 1'b0, 1'b1);
    check("R3", 1'b0, 1'b0, 9'd0);

    // R7: run limit of 3 admissions between releases
    set_cfg(9'd100, 6'd0, 2'd3, 1'b0, 5'd3);
    step(1'b1, 1'b1, 1'b0); check("R7", 1'b1, 1'b0, 9'd1);
    step(1'b1, 1'b1, 1'b0); check("R7", 1'b1, 1'b0, 9'd2);
    step(1'b1, 1'b1, 1'b0); check("R7", 1'b1, 1'b0, 9'd3);
    step(1'b1, 1'b1, 1'b0); check("R7", 1'b0, 1'b1, 9'd3);
    step(1'b0, 1'b0, 1'b1); check("R7", 1'b0, 1'b0, 9'd2);
    step(1'b1, 1'b1, 1'b0); check("R7", 1'b1, 1'b0, 9'd3);
    set_cfg(9'd100, 6'd0, 2'd3, 1'b0, 5'd0);  // zero disables the run limit
    step(1'b1, 1'b0, 1'b0); check("R7", 1'b1, 1'b0, 9'd4);
    step(1'b1, 1'b0, 1'b0); check("R7", 1'b1, 1'b0, 9'd5);

    // R4: reservation at or above the cap refuses everything
    do_reset();
    set_cfg(9'd4, 6'd10, 2'd3, 1'b0, 5'd0);
    step(1'b1, 1'b1, 1'b0); check("R4", 1'b0, 1'b1, 9'd0);
    set_cfg(9'd4, 6'd4, 2'd3, 1'b0, 5'd0);
    step(1'b1, 1'b0, 1'b0); check("R4", 1'b0, 1'b1, 9'd0);

    // R5: cap 7 at 75% truncates to 3+1 = 4
    set_cfg(9'd7, 6'd0, 2'd2, 1'b1, 5'd0);
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b0, 1'b0);
      check("R5", 1'b1, 1'b0, 9'(k + 1));
    end
    step(1'b1, 1'b0, 1'b0); check("R5", 1'b0, 1'b1, 9'd4);
    step(1'b1, 1'b1, 1'b0); check("R6", 1'b1, 1'b0, 9'd5);
    set_cfg(9'd7, 6'd0, 2'd0, 1'b1, 5'd0);  // 25% of 7 = 1
    step(1'b1, 1'b0, 1'b0); check("R8", 1'b0, 1'b1, 9'd5);

    finish_run();
  end

endmodule